// File: doc/BRIEF.md
# SDRAM Refresh and Power-Down Manager

This block keeps a four-bank SDRAM refreshed and takes it in and out of its two low-power states. A free-running interval timer produces refresh ticks. In distributed mode each tick becomes one auto-refresh command. In burst mode the ticks are counted instead, and one whole burst of refreshes is issued after a fixed number of them. When the banks are busy, distributed refreshes are held back in a small saturating counter of postponed refreshes, and they are issued one after another once the banks go idle.

The block does not drive the command bus directly. It raises `busReq` to the main command arbiter, and it acts only in a cycle that follows one in which both `grant` and the bank tracker's `banksIdle` were high. While it holds the bus it issues auto refresh, clock-enable power-down, or self-refresh entry. It then keeps NOPs on the bus for the recovery windows. On leaving self refresh in burst mode, it issues a full burst before it gives the bus back. Refresh work always takes priority over power-saving requests.

Top module: `refresh_power_mgr`

## Requirements
- R1: While reset is held and right after it, `cke` is 1, `busReq` is 0, and the bus is deselected (`csN`=1, `rasN`=`casN`=`weN`=1).
- R2: In distributed mode (`burstMode`=0) one refresh is owed every REF_INTERVAL cycles. With the banks idle and the bus granted, each owed refresh produces exactly one auto-refresh command.
- R3: The auto-refresh command is `csN`=0, `rasN`=0, `casN`=0, `weN`=1 with `cke`=1, held for one cycle.
- R4: Auto refresh, self-refresh entry and power-down entry only start in the cycle after one where `grant` and `banksIdle` were both 1. While waiting for them, `busReq` stays 1 and no command is issued.
- R5: At least TRC NOP cycles (`csN`=0, `rasN`=`casN`=`weN`=1, `cke`=1) follow every auto refresh before the next command.
- R6: Up to MAX_PENDING owed refreshes are kept while the banks are busy. Further ticks are dropped. When the banks become idle, all kept refreshes are issued back to back.
- R7: With `pdReq`=1 and nothing owed, `cke` goes to 0 once the bus is granted and the banks are idle. While `cke` is 0, only NOPs appear on the bus.
- R8: After `pdReq` falls, `cke` returns to 1 at the next clock with a NOP on the bus, and the bus is released two cycles later when nothing else is pending.
- R9: A refresh that becomes owed during power-down wakes the device, the refresh is issued, and power-down is re-entered while `pdReq` is still 1.
- R10: Self-refresh entry is the auto-refresh encoding with `cke`=0 for one cycle. `cke` then stays 0 while `srReq`=1, and refresh ticks in that time are discarded.
- R11: After `srReq` falls, `cke` returns to 1 at the next clock and TRC NOP cycles follow with the bus still held.
- R12: On self-refresh exit in burst mode exactly BURST_COUNT refreshes are issued before the bus is released. In distributed mode none are issued and the bus is released two cycles after the NOP window.
- R13: In burst mode, every BURST_COUNT refresh ticks one burst of BURST_COUNT refreshes is issued, and no single refreshes are issued in between.
- R14: Owed refreshes are issued before a pending self-refresh or power-down entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| banksIdle | input | 1 | All four banks are precharged and idle |
| grant | input | 1 | Arbiter hands the command bus to this block |
| burstMode | input | 1 | 1: burst refresh, 0: distributed refresh |
| pdReq | input | 1 | Request to stay in clock-enable power-down |
| srReq | input | 1 | Request to stay in self refresh |
| busReq | output | 1 | Command bus requested or held |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the SDRAM |

## Verification
The hardest cases to reach are the ones that hinge on where the free-running refresh timer stands: a saturated postponement queue, a tick landing during power-down, and the burst that follows self-refresh exit while the burst-mode tick counter is also counting. Each scenario first waits for an auto-refresh command on the bus. That fixes the timer phase to within a cycle, so each scenario can hold `banksIdle` low or keep `srReq` high for a whole number of intervals and count the exact number of refresh commands that must follow. A bus monitor checks, across the whole run, the spacing between refreshes and that only NOPs appear while `cke` is low.

// File: rtl/rfpm_pkg.sv
package rfpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_REF,
    ST_RWAIT,
    ST_PDOWN,
    ST_PDEXIT,
    ST_SRENT,
    ST_SELF,
    ST_SREXIT
  } rfpm_state_e;

  typedef struct packed {
    logic tickEn;
    logic decRef;
    logic loadWait;
    logic loadBurst;
  } rfpm_strobe_t;

endpackage

// File: rtl/rfpm_datapath.sv
module rfpm_datapath
  import rfpm_pkg::*;
#(
  parameter int REF_INTERVAL = 780,
  parameter int TRC          = 4,
  parameter int BURST_COUNT  = 4096,
  parameter int MAX_PENDING  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         burstMode,
  input  rfpm_strobe_t strobes,
  output logic         refNeed,
  output logic         waitDone
);

  localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int WW = $clog2(TRC + 1);
  localparam int BW = $clog2(BURST_COUNT + 1);
  localparam int EW = (BURST_COUNT > 1) ? $clog2(BURST_COUNT) : 1;
  localparam int PW = $clog2(MAX_PENDING + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(REF_INTERVAL - 1);
  localparam logic [WW-1:0] WAIT_INIT  = WW'(TRC - 1);
  localparam logic [BW-1:0] BURST_MAX  = BW'(BURST_COUNT);
  localparam logic [EW-1:0] EPOCH_LAST = EW'(BURST_COUNT - 1);
  localparam logic [PW-1:0] PEND_MAX   = PW'(MAX_PENDING);

  logic [TW-1:0] timerCnt;
  logic [WW-1:0] waitCnt;
  logic [BW-1:0] burstLeft;
  logic [EW-1:0] epochCnt;
  logic [PW-1:0] pending;

  logic tick, liveTick, pendInc, pendDec, burstDec, epochWrap;

  assign tick      = (timerCnt == TIMER_LAST);
  assign liveTick  = tick && strobes.tickEn;
  assign pendInc   = liveTick && !burstMode && (pending != PEND_MAX);
  assign burstDec  = strobes.decRef && (burstLeft != '0);
  assign pendDec   = strobes.decRef && (burstLeft == '0) && (pending != '0);
  assign epochWrap = liveTick && burstMode && (epochCnt == EPOCH_LAST);
  assign refNeed   = (pending != '0) || (burstLeft != '0);
  assign waitDone  = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) timerCnt <= '0;
    else if (tick) timerCnt <= '0;
    else timerCnt <= timerCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else if (pendInc && !pendDec) pending <= pending + 1'b1;
    else if (pendDec && !pendInc) pending <= pending - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) epochCnt <= '0;
    else if (epochWrap) epochCnt <= '0;
    else if (liveTick && burstMode) epochCnt <= epochCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) burstLeft <= '0;
    else if (strobes.loadBurst || epochWrap) burstLeft <= BURST_MAX;
    else if (burstDec) burstLeft <= burstLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (strobes.loadWait) waitCnt <= WAIT_INIT;
    else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end

  // R6
  pend_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending <= PEND_MAX);

  // R12
  burst_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBurst |=> (burstLeft == BURST_MAX));

endmodule

// File: rtl/rfpm_control.sv
module rfpm_control
  import rfpm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         banksIdle,
  input  logic         grant,
  input  logic         burstMode,
  input  logic         pdReq,
  input  logic         srReq,
  input  logic         refNeed,
  input  logic         waitDone,
  output rfpm_strobe_t strobes,
  output logic         busReq,
  output logic         csN,
  output logic         rasN,
  output logic         casN,
  output logic         weN,
  output logic         cke
);

  rfpm_state_e state, nextState;
  logic anyWork, busOk;

  assign anyWork = refNeed || srReq || pdReq;
  assign busOk   = grant && banksIdle;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    strobes.tickEn = !(state inside {ST_SRENT, ST_SELF, ST_SREXIT});
    case (state)
      ST_IDLE:   if (anyWork) nextState = ST_REQ;
      ST_REQ: begin
        if (busOk) begin
          if (refNeed)    nextState = ST_REF;
          else if (srReq) nextState = ST_SRENT;
          else if (pdReq) nextState = ST_PDOWN;
          else            nextState = ST_IDLE;
        end else if (!anyWork) begin
          nextState = ST_IDLE;
        end
      end
      ST_REF: begin
        strobes.decRef   = 1'b1;
        strobes.loadWait = 1'b1;
        nextState        = ST_RWAIT;
      end
      ST_RWAIT:  if (waitDone) nextState = ST_REQ;
      ST_PDOWN:  if (!pdReq || refNeed) nextState = ST_PDEXIT;
      ST_PDEXIT: nextState = ST_REQ;
      ST_SRENT:  nextState = ST_SELF;
      ST_SELF: begin
        if (!srReq) begin
          strobes.loadWait = 1'b1;
          nextState        = ST_SREXIT;
        end
      end
      ST_SREXIT: begin
        if (waitDone) begin
          strobes.loadBurst = burstMode;
          nextState         = ST_REQ;
        end
      end
      default:   nextState = ST_IDLE;
    endcase
  end

  assign busReq = (state != ST_IDLE);
  assign csN    = (state == ST_IDLE);
  assign rasN   = !(state inside {ST_REF, ST_SRENT});
  assign casN   = rasN;
  assign weN    = 1'b1;
  assign cke    = !(state inside {ST_PDOWN, ST_SRENT, ST_SELF});

  // R4
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REF) |-> $past(grant && banksIdle));

  // R10
  self_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELF && srReq) |=> !cke);

endmodule

// File: rtl/refresh_power_mgr.sv
module refresh_power_mgr
  import rfpm_pkg::*;
#(
  parameter int REF_INTERVAL = 780,
  parameter int TRC          = 4,
  parameter int BURST_COUNT  = 4096,
  parameter int MAX_PENDING  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic banksIdle,
  input  logic grant,
  input  logic burstMode,
  input  logic pdReq,
  input  logic srReq,
  output logic busReq,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic cke
);

  rfpm_strobe_t strobes;
  logic refNeed, waitDone;

  rfpm_control u_ctrl (
    .clk(clk), .rstN(rstN), .banksIdle(banksIdle), .grant(grant),
    .burstMode(burstMode), .pdReq(pdReq), .srReq(srReq),
    .refNeed(refNeed), .waitDone(waitDone), .strobes(strobes),
    .busReq(busReq), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke)
  );

  rfpm_datapath #(
    .REF_INTERVAL(REF_INTERVAL), .TRC(TRC),
    .BURST_COUNT(BURST_COUNT), .MAX_PENDING(MAX_PENDING)
  ) u_dp (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .strobes(strobes),
    .refNeed(refNeed), .waitDone(waitDone)
  );

  // R7
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> $past(grant && banksIdle));

  // R5
  ar_then_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && cke) |=> (rasN && casN && cke));

  // R1
  cke_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> cke);

endmodule

// File: tb/refresh_power_mgr_test.sv
module refresh_power_mgr_test;

  localparam int INTERVAL = 40;
  localparam int TRC      = 3;
  localparam int BURST    = 6;
  localparam int MAXP     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic banksIdle = 1'b1, grant = 1'b0, burstMode = 1'b0;
  logic pdReq = 1'b0, srReq = 1'b0;
  logic busReq, csN, rasN, casN, weN, cke;

  int errors = 0, checks = 0;
  int arCount = 0, srCount = 0, arAtSr = 0;
  int gapErr = 0, lowErr = 0, cyc = 0, lastAr = -1000;

  always #10 clk = ~clk;

  refresh_power_mgr #(
    .REF_INTERVAL(INTERVAL), .TRC(TRC), .BURST_COUNT(BURST), .MAX_PENDING(MAXP)
  ) uut (
    .clk(clk), .rstN(rstN), .banksIdle(banksIdle), .grant(grant),
    .burstMode(burstMode), .pdReq(pdReq), .srReq(srReq), .busReq(busReq),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cke(cke)
  );

  // arbiter model: grants whenever requested
  always @(negedge clk) grant <= rstN && busReq;

  // bus monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (!csN && !rasN && !casN && weN && cke) begin
        if (cyc - lastAr < TRC + 1) gapErr <= gapErr + 1;
        lastAr  <= cyc;
        arCount <= arCount + 1;
      end
      if (!csN && !rasN && !casN && weN && !cke) begin
        srCount <= srCount + 1;
        arAtSr  <= arCount;
      end
      if (!cke && !(!csN && rasN && casN && weN) && !(!csN && !rasN && !casN && weN))
        lowErr <= lowErr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic syncAr();
    int base = arCount;
    while (arCount == base) step(1);
  endtask

  task automatic testReset();
    check(cke == 1'b1, "R1 cke", cke, 1);
    check(busReq == 1'b0, "R1 busReq", busReq, 0);
    check(csN == 1'b1, "R1 csN", csN, 1);
    check({rasN, casN, weN} == 3'b111, "R1 ras/cas/we", {rasN, casN, weN}, 7);
  endtask

  task automatic testDistributed();
    int base;
    while (rasN) step(1);
    check(!csN && !casN && weN && cke, "R3 auto refresh encoding",
          {csN, casN, weN, cke}, 4'b0011);
    syncAr();
    base = arCount;
    step(4 * INTERVAL + INTERVAL / 2);
    check(arCount - base == 4, "R2 refreshes per interval", arCount - base, 4);
    check(busReq == 1'b0, "R2 bus released between refreshes", busReq, 0);
    check(gapErr == 0, "R5 nop window after refresh", gapErr, 0);
  endtask

  task automatic testPostpone();
    int base;
    syncAr();
    banksIdle = 1'b0;
    base = arCount;
    step(3 * INTERVAL);
    check(arCount == base, "R4 no refresh while banks busy", arCount - base, 0);
    check(busReq == 1'b1, "R4 request held while waiting", busReq, 1);
    banksIdle = 1'b1;
    step(25);
    check(arCount - base == 3, "R6 postponed refreshes issued", arCount - base, 3);
    syncAr();
    banksIdle = 1'b0;
    base = arCount;
    step(6 * INTERVAL);
    banksIdle = 1'b1;
    step(30);
    check(arCount - base == MAXP, "R6 postponed count saturates", arCount - base, MAXP);
  endtask

  task automatic testPowerDown();
    int base;
    syncAr();
    base = arCount;
    pdReq = 1'b1;
    step(10);
    check(cke == 1'b0, "R7 cke low in power-down", cke, 0);
    check(busReq == 1'b1, "R7 bus held in power-down", busReq, 1);
    step(10);
    pdReq = 1'b0;
    step(1);
    check(cke == 1'b1 && rasN && !csN, "R8 cke high with NOP on exit",
          {cke, rasN, csN}, 3'b110);
    step(2);
    check(busReq == 1'b0, "R8 bus released after exit", busReq, 0);
    check(arCount == base, "R8 no refresh around power-down", arCount - base, 0);
  endtask

  task automatic testPowerDownWake();
    int base;
    syncAr();
    base = arCount;
    pdReq = 1'b1;
    step(INTERVAL + INTERVAL / 2);
    check(arCount - base == 1, "R9 refresh issued during power-down", arCount - base, 1);
    check(cke == 1'b0, "R9 power-down re-entered", cke, 0);
    pdReq = 1'b0;
    step(5);
  endtask

  task automatic testSelfRefresh();
    int base, sbase;
    syncAr();
    base = arCount;
    sbase = srCount;
    srReq = 1'b1;
    step(2 * INTERVAL);
    check(srCount - sbase == 1, "R10 one self-refresh entry", srCount - sbase, 1);
    check(cke == 1'b0, "R10 cke held low", cke, 0);
    check(arCount == base, "R10 ticks discarded in self refresh", arCount - base, 0);
    srReq = 1'b0;
    step(1);
    check(cke == 1'b1 && rasN, "R11 cke high with NOP on exit", {cke, rasN}, 2'b11);
    step(TRC - 1);
    check(busReq == 1'b1 && cke, "R11 bus held through NOP window", {busReq, cke}, 2'b11);
    step(2);
    check(busReq == 1'b0, "R12 distributed mode releases bus", busReq, 0);
    step(5);
    check(arCount == base, "R12 no burst in distributed mode", arCount - base, 0);
  endtask

  task automatic testPriority();
    int base, sbase;
    syncAr();
    banksIdle = 1'b0;
    base = arCount;
    sbase = srCount;
    step(2 * INTERVAL);
    srReq = 1'b1;
    banksIdle = 1'b1;
    step(30);
    check(arCount - base == 2, "R14 owed refreshes issued", arCount - base, 2);
    check(srCount - sbase == 1 && arAtSr == base + 2, "R14 refreshes before self refresh",
          arAtSr - base, 2);
    srReq = 1'b0;
    step(20);
  endtask

  task automatic testBurst();
    int base;
    syncAr();
    burstMode = 1'b1;
    srReq = 1'b1;
    step(2 * INTERVAL);
    base = arCount;
    srReq = 1'b0;
    step(60);
    check(arCount - base == BURST, "R12 full burst after self-refresh exit",
          arCount - base, BURST);
    base = arCount;
    step(6 * INTERVAL);
    check(arCount - base == BURST, "R13 periodic burst", arCount - base, BURST);
    check(gapErr == 0, "R5 gap kept inside bursts", gapErr, 0);
  endtask

  initial begin
    step(3);
    testReset();
    rstN = 1'b1;
    testDistributed();
    testPostpone();
    testPowerDown();
    testPowerDownWake();
    testSelfRefresh();
    testPriority();
    testBurst();
    check(lowErr == 0, "R7 only NOPs while cke low", lowErr, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule